// File: doc/BRIEF.md
# Steerable Interrupt Source Concentrator

This block gathers 32 interrupt request lines and merges them into two processor request outputs, one ordinary and one urgent. Every source has its own detection rule: it can be sensed by level or by transition, and either polarity can be chosen. The condition that is detected is latched in a pending bit. An enable bit lets that pending bit reach the outputs, and a route bit chooses which of the two outputs it drives.

Software reaches the block over a simple word-addressed register port. One access completes in one cycle. Pending bits are cleared by writing ones. A masked view (pending AND enable) shows in one read whether anything is waiting to be served. In every register, source n sits at bit position NSRC-1-n, so source 0 is the most significant bit. A pending bit for a level-sensed source cannot be cleared while its input is still at the active level, and this is true whether or not the source is enabled.

Top module: `irq_route_top`

## Requirements
- R1: After reset, pending (offset 0x0), enable (0x2), route (0x3), sense mode (0x5) and masked view (0x6) read 0, polarity (0x4) reads all ones, and both request outputs are low.
- R2: Source n is held at bit NSRC-1-n of every register, so source 0 is bit 31 and source 5 is bit 26.
- R3: In level mode (mode bit 0), the pending bit is set from the third rising clock edge after the input reaches its active level: high when the polarity bit is 1, low when it is 0. The bit stays set after the input goes inactive, until a one is written to it at offset 0x0.
- R4: Writing a one to the pending bit of a level-sensed source leaves the bit set while the input is still active, even when the source's enable bit is 0.
- R5: In edge mode (mode bit 1), a rising input transition sets the pending bit when the polarity bit is 1, and a falling transition sets it when the polarity bit is 0. The bit then stays set. Writing zeros to offset 0x0 has no effect, and writing a one clears the bit.
- R6: When a detected transition and a one-write to the same pending bit fall in the same cycle, the bit ends up set.
- R7: Offset 0x6 reads pending AND enable. Writes to it are ignored.
- R8: The urgent output is high when some source is pending, enabled and has route bit 1. The ordinary output is high when some source is pending, enabled and has route bit 0.
- R9: Offsets 0x1, 0x7, 0x8 and every offset above 0x8 read as zero. Writes to them change no register.
- R10: A read at an address that is being written in the same cycle returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srcReq | input | NSRC | Raw interrupt inputs, srcReq[n] is source n |
| addr | input | ADDR_W | Register word offset |
| wrData | input | NSRC | Write data |
| wrEn | input | 1 | Write strobe for the current cycle |
| rdData | output | NSRC | Read data for addr, combinational |
| critIrq | output | 1 | Urgent processor request |
| nonCritIrq | output | 1 | Ordinary processor request |

## Verification
A pending bit that is wrongly held or wrongly lost shows up on the next read of offset 0x0 or 0x6. It also shows on the two request pins in that same cycle, because both pins are driven combinationally from the registers. A fault in the detection path appears three clock edges after the input change, once the synchronizer has filled. A corrupted configuration bit shows up at the latest on the next input event for that source, when the wrong polarity, the wrong sense mode or the wrong output is taken.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int OFF_PEND   = 0;
  localparam int OFF_ARM    = 2;
  localparam int OFF_ROUTE  = 3;
  localparam int OFF_POL    = 4;
  localparam int OFF_MODE   = 5;
  localparam int OFF_MASKED = 6;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_PEND, SEL_ARM, SEL_ROUTE, SEL_POL, SEL_MODE, SEL_MASKED
  } rdSel_t;

  typedef struct packed {
    logic clrPend;
    logic wrArm;
    logic wrRoute;
    logic wrPol;
    logic wrMode;
  } strobe_t;
endpackage

// File: rtl/irq_route_srcdet.sv
module irq_route_srcdet (
  input  logic clk,
  input  logic rst,
  input  logic reqRaw,
  input  logic polHigh,
  input  logic edgeMode,
  input  logic clrBit,
  output logic pendBit,
  output logic levelAct
);
  logic syncA, syncB, syncC;
  logic levelHit, edgeHit, setHit;

  // level is judged on the synchronized sample, edge on two successive samples
  assign levelHit = polHigh ? syncB : ~syncB;
  assign edgeHit  = polHigh ? (syncB & ~syncC) : (~syncB & syncC);
  assign setHit   = edgeMode ? edgeHit : levelHit;
  assign levelAct = levelHit & ~edgeMode;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      syncC   <= 1'b0;
      pendBit <= 1'b0;
    end else begin
      syncA   <= reqRaw;
      syncB   <= syncA;
      syncC   <= syncB;
      // a new detection wins over a clear in the same cycle
      pendBit <= setHit | (pendBit & ~clrBit);
    end
  end
endmodule

// File: rtl/irq_route_datapath.sv
module irq_route_datapath
  import irq_route_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] srcReq,
  input  strobe_t         strobe,
  input  logic [NSRC-1:0] wrData,
  output logic [NSRC-1:0] pendReg,
  output logic [NSRC-1:0] armReg,
  output logic [NSRC-1:0] routeReg,
  output logic [NSRC-1:0] polReg,
  output logic [NSRC-1:0] modeReg,
  output logic [NSRC-1:0] maskedReg,
  output logic [NSRC-1:0] levelAct,
  output logic            critIrq,
  output logic            nonCritIrq
);
  logic [NSRC-1:0] clrVec;

  assign clrVec = strobe.clrPend ? wrData : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      armReg   <= '0;
      routeReg <= '0;
      polReg   <= {NSRC{1'b1}};
      modeReg  <= '0;
    end else begin
      if (strobe.wrArm)   armReg   <= wrData;
      if (strobe.wrRoute) routeReg <= wrData;
      if (strobe.wrPol)   polReg   <= wrData;
      if (strobe.wrMode)  modeReg  <= wrData;
    end
  end

  // source n lands on register bit NSRC-1-n
  for (genvar n = 0; n < NSRC; n++) begin : gSrc
    localparam int B = NSRC - 1 - n;
    irq_route_srcdet uDet (
      .clk      (clk),
      .rst      (rst),
      .reqRaw   (srcReq[n]),
      .polHigh  (polReg[B]),
      .edgeMode (modeReg[B]),
      .clrBit   (clrVec[B]),
      .pendBit  (pendReg[B]),
      .levelAct (levelAct[B])
    );
  end

  assign maskedReg  = pendReg & armReg;
  assign critIrq    = |(maskedReg & routeReg);
  assign nonCritIrq = |(maskedReg & ~routeReg);
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [NSRC-1:0]   pendReg,
  input  logic [NSRC-1:0]   armReg,
  input  logic [NSRC-1:0]   routeReg,
  input  logic [NSRC-1:0]   polReg,
  input  logic [NSRC-1:0]   modeReg,
  input  logic [NSRC-1:0]   maskedReg,
  output strobe_t           strobe,
  output logic [NSRC-1:0]   rdData
);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_ARM    = ADDR_W'(OFF_ARM);
  localparam logic [ADDR_W-1:0] A_ROUTE  = ADDR_W'(OFF_ROUTE);
  localparam logic [ADDR_W-1:0] A_POL    = ADDR_W'(OFF_POL);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFF_MODE);
  localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFF_MASKED);

  rdSel_t sel;

  always_comb begin
    sel = SEL_NONE;
    if      (addr == A_PEND)   sel = SEL_PEND;
    else if (addr == A_ARM)    sel = SEL_ARM;
    else if (addr == A_ROUTE)  sel = SEL_ROUTE;
    else if (addr == A_POL)    sel = SEL_POL;
    else if (addr == A_MODE)   sel = SEL_MODE;
    else if (addr == A_MASKED) sel = SEL_MASKED;
  end

  always_comb begin
    strobe         = '0;
    strobe.clrPend = wrEn && (sel == SEL_PEND);
    strobe.wrArm   = wrEn && (sel == SEL_ARM);
    strobe.wrRoute = wrEn && (sel == SEL_ROUTE);
    strobe.wrPol   = wrEn && (sel == SEL_POL);
    strobe.wrMode  = wrEn && (sel == SEL_MODE);
  end

  // reads see the registers as they stand before this cycle's write
  always_comb begin
    case (sel)
      SEL_PEND:   rdData = pendReg;
      SEL_ARM:    rdData = armReg;
      SEL_ROUTE:  rdData = routeReg;
      SEL_POL:    rdData = polReg;
      SEL_MODE:   rdData = modeReg;
      SEL_MASKED: rdData = maskedReg;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   srcReq,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wrData,
  input  logic              wrEn,
  output logic [NSRC-1:0]   rdData,
  output logic              critIrq,
  output logic              nonCritIrq
);
  strobe_t         strobe;
  logic [NSRC-1:0] pendReg, armReg, routeReg, polReg, modeReg, maskedReg, levelAct;

  irq_route_ctrl #(.NSRC(NSRC), .ADDR_W(ADDR_W)) uCtrl (
    .addr      (addr),
    .wrEn      (wrEn),
    .pendReg   (pendReg),
    .armReg    (armReg),
    .routeReg  (routeReg),
    .polReg    (polReg),
    .modeReg   (modeReg),
    .maskedReg (maskedReg),
    .strobe    (strobe),
    .rdData    (rdData)
  );

  irq_route_datapath #(.NSRC(NSRC)) uDp (
    .clk        (clk),
    .rst        (rst),
    .srcReq     (srcReq),
    .strobe     (strobe),
    .wrData     (wrData),
    .pendReg    (pendReg),
    .armReg     (armReg),
    .routeReg   (routeReg),
    .polReg     (polReg),
    .modeReg    (modeReg),
    .maskedReg  (maskedReg),
    .levelAct   (levelAct),
    .critIrq    (critIrq),
    .nonCritIrq (nonCritIrq)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [NSRC-1:0]   wrData,
  input logic              wrEn,
  input logic              critIrq,
  input logic              nonCritIrq,
  input logic [NSRC-1:0]   pendReg,
  input logic [NSRC-1:0]   armReg,
  input logic [NSRC-1:0]   routeReg,
  input logic [NSRC-1:0]   polReg,
  input logic [NSRC-1:0]   modeReg,
  input logic [NSRC-1:0]   levelAct
);
  logic [NSRC-1:0] clrMask;
  logic            deadAddr;

  assign clrMask  = (wrEn && addr == '0) ? wrData : '0;
  assign deadAddr = wrEn && (addr == ADDR_W'(1) || addr > ADDR_W'(6));

  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (levelAct != '0) |=> ((pendReg & $past(levelAct)) == $past(levelAct))); // R4

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pendReg & $past(pendReg & ~clrMask)) == $past(pendReg & ~clrMask))); // R3

  AST_DEAD_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
    deadAddr |=> ($stable(armReg) && $stable(routeReg) && $stable(polReg) && $stable(modeReg))); // R9

  AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (armReg == '0) |-> (!critIrq && !nonCritIrq)); // R8
endmodule

bind irq_route_top irq_route_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) uChk (
  .clk        (clk),
  .rst        (rst),
  .addr       (addr),
  .wrData     (wrData),
  .wrEn       (wrEn),
  .critIrq    (critIrq),
  .nonCritIrq (nonCritIrq),
  .pendReg    (pendReg),
  .armReg     (armReg),
  .routeReg   (routeReg),
  .polReg     (polReg),
  .modeReg    (modeReg),
  .levelAct   (levelAct)
);

// File: tb/sim_irq_route_top.sv
`timescale 1ns/1ps
module sim_irq_route_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] srcReq = '0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic [31:0] rdData;
  logic        critIrq, nonCritIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          pins;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];
  event  sampleEv;

  irq_route_top u0 (
    .clk(clk), .rst(rst), .srcReq(srcReq), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdData(rdData), .critIrq(critIrq), .nonCritIrq(nonCritIrq)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] bitOf(int n);
    return 32'h1 << (31 - n);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic expReg(logic [3:0] a, logic [31:0] e, string tag);
    item_t it;
    addr = a;
    it.pins = 0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    -> sampleEv;
    #1.5;
    @(negedge clk);
  endtask

  task automatic expPins(logic crit, logic nonCrit, string tag);
    item_t it;
    it.pins = 1; it.exp = {30'b0, crit, nonCrit}; it.tag = tag;
    sbq.push_back(it);
    -> sampleEv;
    #1.5;
    @(negedge clk);
  endtask

  // monitor: compares design outputs against queued expectations
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      @(sampleEv);
      #1;
      it = sbq.pop_front();
      act = it.pins ? {30'b0, critIrq, nonCritIrq} : rdData;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    expReg(4'h0, 32'h0, "R1 pending");
    expReg(4'h2, 32'h0, "R1 enable");
    expReg(4'h3, 32'h0, "R1 route");
    expReg(4'h4, 32'hFFFFFFFF, "R1 polarity");
    expReg(4'h5, 32'h0, "R1 mode");
    expReg(4'h6, 32'h0, "R1 masked");
    expPins(1'b0, 1'b0, "R1 pins");

    // R2 / R3 level high on sources 0 and 5
    wr(4'h2, 32'hFFFFFFFF);
    srcReq[0] = 1'b1; srcReq[5] = 1'b1;
    tick(4);
    expReg(4'h0, bitOf(0) | bitOf(5), "R2 bit order src0->31 src5->26");
    expReg(4'h6, 32'h84000000, "R7 masked all enabled");
    expPins(1'b0, 1'b1, "R8 ordinary output");

    // R4 clear blocked while active, even disabled
    wr(4'h2, 32'h0);
    wr(4'h0, 32'hFFFFFFFF);
    expReg(4'h0, 32'h84000000, "R4 clear while active");
    expPins(1'b0, 1'b0, "R8 disabled quiet");
    srcReq[0] = 1'b0; srcReq[5] = 1'b0;
    tick(4);
    expReg(4'h0, 32'h84000000, "R3 latched after input drop");
    wr(4'h0, 32'hFFFFFFFF);
    expReg(4'h0, 32'h0, "R3 clear when inactive");

    // R3 level low on source 3
    wr(4'h4, ~bitOf(3));
    tick(3);
    expReg(4'h0, bitOf(3), "R3 active-low level");
    srcReq[3] = 1'b1;
    tick(4);
    wr(4'h0, bitOf(3));
    expReg(4'h0, 32'h0, "R3 active-low cleared");
    wr(4'h4, 32'hFFFFFFFF);
    srcReq[3] = 1'b0;
    tick(4);
    wr(4'h0, bitOf(3));
    expReg(4'h0, 32'h0, "R3 restore clean");

    // R5 rising edge on source 7
    wr(4'h5, bitOf(7));
    srcReq[7] = 1'b1;
    tick(2);
    srcReq[7] = 1'b0;
    tick(4);
    expReg(4'h0, bitOf(7), "R5 rising edge sticky");
    wr(4'h0, 32'h0);
    expReg(4'h0, bitOf(7), "R5 zero write no effect");
    wr(4'h0, bitOf(7));
    expReg(4'h0, 32'h0, "R5 one write clears");

    // R5 falling edge
    wr(4'h4, ~bitOf(7));
    srcReq[7] = 1'b1;
    tick(4);
    expReg(4'h0, 32'h0, "R5 rise ignored in falling mode");
    srcReq[7] = 1'b0;
    tick(4);
    expReg(4'h0, bitOf(7), "R5 falling edge");
    wr(4'h0, bitOf(7));
    wr(4'h4, 32'hFFFFFFFF);
    expReg(4'h0, 32'h0, "R5 falling cleared");

    // R6 set beats clear in the same cycle
    srcReq[7] = 1'b1;
    tick(2);
    wr(4'h0, bitOf(7));
    srcReq[7] = 1'b0;
    expReg(4'h0, bitOf(7), "R6 set wins");

    // R7 masked view
    expReg(4'h6, 32'h0, "R7 masked disabled");
    wr(4'h6, 32'hFFFFFFFF);
    expReg(4'h6, 32'h0, "R7 write ignored");
    wr(4'h2, bitOf(7));
    expReg(4'h6, bitOf(7), "R7 masked enabled");
    expPins(1'b0, 1'b1, "R8 ordinary route");

    // R8 routing
    wr(4'h3, bitOf(7));
    expPins(1'b1, 1'b0, "R8 urgent route");
    expReg(4'h3, bitOf(7), "R8 route readback");
    wr(4'h2, 32'h0);
    expPins(1'b0, 1'b0, "R8 disabled");

    // R9 dead offsets
    expReg(4'h1, 32'h0, "R9 offset 1");
    expReg(4'h7, 32'h0, "R9 offset 7");
    expReg(4'h8, 32'h0, "R9 offset 8");
    expReg(4'hF, 32'h0, "R9 offset F");
    wr(4'h1, 32'hFFFFFFFF);
    wr(4'h7, 32'hFFFFFFFF);
    wr(4'h8, 32'hFFFFFFFF);
    wr(4'hF, 32'hFFFFFFFF);
    expReg(4'h2, 32'h0, "R9 enable kept");
    expReg(4'h3, bitOf(7), "R9 route kept");
    expReg(4'h4, 32'hFFFFFFFF, "R9 polarity kept");
    expReg(4'h5, bitOf(7), "R9 mode kept");
    expReg(4'h0, bitOf(7), "R9 pending kept");

    // R10 read during write shows old value
    begin
      item_t it;
      addr = 4'h5; wrData = 32'h0; wrEn = 1'b1;
      it.pins = 0; it.exp = bitOf(7); it.tag = "R10 old value during write";
      sbq.push_back(it);
      -> sampleEv;
      #1.5;
      @(negedge clk);
      wrEn = 1'b0;
    end
    expReg(4'h5, 32'h0, "R10 new value after write");

    tick(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule